// File: doc/BRIEF.md
# Stereo Soft Mute Gain Ramp

This block sits in a digital audio path and fades a stereo PCM stream into and out of silence without an audible click. A per-channel gain index, held inside the block, scales every sample. When a mute is requested, the index walks down one step at a time to zero. At zero the output is silent. When the request is withdrawn, the index walks back up to the programmed attenuation code. The walk always starts from wherever the index currently sits, so a mute released partway down turns around at that point. The climb back up runs at the same rate as the descent.

Mute can be requested from a board pin or from a control register bit, and either one is enough. The index moves only on frame strobes, one step every `STEP_FRAMES` strobes. A full fade from code N therefore lasts N times that many frames. If the attenuation code changes while no mute is active, the index glides to the new code at the same rate instead of jumping. Each output sample is registered and appears one clock after the strobe that carried its input.

Top module: `soft_mute_ramp`

## Requirements
- R1: The mute request is the OR of `mute_pin` and `mute_reg`. Either one alone, or both together, drives the gain index toward zero.
- R2: While mute is requested, the gain index drops by one per step until it reaches 0. At 0 both outputs are exactly zero.
- R3: While no mute is requested, the index rises by one per step from its present value until it equals `att_level`. A release in the middle of a fade reverses from the current index.
- R4: A step happens on every `STEP_FRAMES`-th (default 4) assertion of `frame_valid`, counted by a free-running prescaler. Clock cycles without `frame_valid` do not advance it.
- R5: Each output equals input × index / 255, truncated toward zero with the sign kept. Both channels are computed this way. The result is registered, and `out_valid` is high in the cycle after the `frame_valid` cycle. The index used is the value held before that strobe's own step.
- R6: If `att_level` changes while unmuted, the index moves toward the new code one step at a time, in either direction.
- R7: Reset (synchronous, active high) clears both outputs and `out_valid`, loads the index from `att_level`, and clears the prescaler.
- R8: Between consecutive clock cycles, the index changes by at most one, and only on a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle strobe marking a new stereo sample pair |
| left_in | input | SAMPLE_W | Left input sample, two's complement |
| right_in | input | SAMPLE_W | Right input sample, two's complement |
| mute_pin | input | 1 | Mute request from the board pin |
| mute_reg | input | 1 | Mute request from the control register |
| att_level | input | ATT_W | Programmed attenuation code, 0 (silent) to 255 (unity) |
| left_out | output | SAMPLE_W | Scaled left sample |
| right_out | output | SAMPLE_W | Scaled right sample |
| out_valid | output | 1 | High for one cycle when the outputs carry a new pair |

## Verification
The main stimulus is a constant pair, +255000 and −255000, so each output equals ±1000 times the index. These samples expose the index directly at the ports. Runs of strobes are applied under pin-only, register-only and combined mute requests. Long runs show a complete fade to silence and a capped climb. Short runs release partway down and separate a true reversal from a restart at the full level. A downward change of the attenuation code with no mute shows that the index glides rather than jumps. Idle gaps of different lengths between strobes show that the step counts strobes and not clocks. A full-scale positive sample and a small negative sample exercise truncation toward zero. A reset taken at an odd prescaler phase shows the prescaler is cleared.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_UP   = 2'd1,
        RAMP_DOWN = 2'd2
    } ramp_dir_e;

    // Largest gain code for a given index width: maps to unity gain.
    function automatic int unsigned full_scale(input int unsigned width);
        return (32'd1 << width) - 32'd1;
    endfunction

    // Direction the index must move to approach its target.
    function automatic ramp_dir_e pick_dir(input int unsigned cur, input int unsigned tgt);
        if (cur < tgt)      return RAMP_UP;
        else if (cur > tgt) return RAMP_DOWN;
        else                return RAMP_HOLD;
    endfunction

    // Width of a counter that must hold values 0..n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/smr_step_timer.sv
module smr_step_timer #(
    parameter int unsigned STEP_FRAMES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic tick_o
);
    localparam int unsigned CW = smr_pkg::cnt_width(STEP_FRAMES);
    localparam logic [CW-1:0] LAST = CW'(STEP_FRAMES - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = strobe_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (strobe_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Idle cycles must not move the prescaler.
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(strobe_i) |-> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/smr_gain_ramp.sv
module smr_gain_ramp #(
    parameter int unsigned ATT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             mute_i,
    input  logic [ATT_W-1:0] att_i,
    output logic [ATT_W-1:0] gain_o
);
    import smr_pkg::*;

    logic [ATT_W-1:0] target;
    ramp_dir_e        dir;

    always_comb begin
        target = mute_i ? '0 : att_i;
        dir    = pick_dir(int'(gain_o), int'(target));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_o <= att_i;
        end else if (tick_i) begin
            unique case (dir)
                RAMP_UP:   gain_o <= gain_o + 1'b1;
                RAMP_DOWN: gain_o <= gain_o - 1'b1;
                default:   gain_o <= gain_o;
            endcase
        end
    end

    assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
        (gain_o != $past(gain_o)) |->
            ((gain_o == ATT_W'($past(gain_o) + 1'b1)) || (gain_o == ATT_W'($past(gain_o) - 1'b1))));

    assert_move_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (gain_o != $past(gain_o)) |-> $past(tick_i));

    assert_muted_no_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $past(mute_i) |-> (gain_o <= $past(gain_o)));

    assert_unmuted_no_fall_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(mute_i) && ($past(gain_o) < $past(att_i))) |-> (gain_o >= $past(gain_o)));

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned ATT_W    = 8,
    parameter int unsigned CH       = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         valid_i,
    input  logic [ATT_W-1:0]             gain_i,
    input  logic [CH-1:0][SAMPLE_W-1:0]  samp_i,
    output logic [CH-1:0][SAMPLE_W-1:0]  samp_o,
    output logic                         valid_o
);
    localparam int unsigned PW = SAMPLE_W + ATT_W + 2;
    localparam logic signed [PW-1:0] DIVISOR = PW'(smr_pkg::full_scale(ATT_W));

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= valid_i;
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic signed [PW-1:0] s_ext;
        logic signed [PW-1:0] g_ext;
        logic signed [PW-1:0] quo;

        always_comb begin
            s_ext = {{(PW-SAMPLE_W){samp_i[c][SAMPLE_W-1]}}, samp_i[c]};
            g_ext = {{(PW-ATT_W){1'b0}}, gain_i};
            // Signed division truncates toward zero.
            quo   = (s_ext * g_ext) / DIVISOR;
        end

        always_ff @(posedge clk) begin
            if (rst)          samp_o[c] <= '0;
            else if (valid_i) samp_o[c] <= quo[SAMPLE_W-1:0];
        end

        assert_silent_at_zero_R2: assert property (@(posedge clk) disable iff (rst)
            $past(valid_i && (gain_i == '0)) |-> (samp_o[c] == '0));

        assert_unity_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
            $past(valid_i && (&gain_i)) |-> (samp_o[c] == $past(samp_i[c])));
    end

endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp #(
    parameter int unsigned SAMPLE_W    = 24,
    parameter int unsigned ATT_W       = 8,
    parameter int unsigned STEP_FRAMES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_valid,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                mute_pin,
    input  logic                mute_reg,
    input  logic [ATT_W-1:0]    att_level,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                out_valid
);
    localparam int unsigned NCH = 2;

    logic                         step_tick;
    logic                         mute_req;
    logic [ATT_W-1:0]             gain;
    logic [NCH-1:0][SAMPLE_W-1:0] pair_in;
    logic [NCH-1:0][SAMPLE_W-1:0] pair_out;

    assign mute_req = mute_pin | mute_reg;
    assign pair_in  = {right_in, left_in};
    assign left_out  = pair_out[0];
    assign right_out = pair_out[1];

    smr_step_timer #(.STEP_FRAMES(STEP_FRAMES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (frame_valid),
        .tick_o   (step_tick)
    );

    smr_gain_ramp #(.ATT_W(ATT_W)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .tick_i (step_tick),
        .mute_i (mute_req),
        .att_i  (att_level),
        .gain_o (gain)
    );

    smr_scaler #(.SAMPLE_W(SAMPLE_W), .ATT_W(ATT_W), .CH(NCH)) u_scale (
        .clk     (clk),
        .rst     (rst),
        .valid_i (frame_valid),
        .gain_i  (gain),
        .samp_i  (pair_in),
        .samp_o  (pair_out),
        .valid_o (out_valid)
    );

endmodule

// File: tb/soft_mute_ramp_tb_top.sv
module soft_mute_ramp_tb_top;

    localparam int SW = 24;

    typedef struct packed {
        logic        pin;
        logic        rg;
        logic [7:0]  att;
        logic [15:0] frames;
        logic [23:0] sl;
        logic [23:0] sr;
        logic [7:0]  exp_gain;
    } vec_t;

    // exp_gain: index applied to the last frame of each row.
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd200, 16'd8,   24'd255000, -24'sd255000, 8'd200},
        '{1'b1, 1'b0, 8'd200, 16'd40,  24'd255000, -24'sd255000, 8'd191},
        '{1'b0, 1'b0, 8'd200, 16'd20,  24'd255000, -24'sd255000, 8'd194},
        '{1'b0, 1'b1, 8'd200, 16'd800, 24'd255000, -24'sd255000, 8'd0},
        '{1'b0, 1'b1, 8'd50,  16'd8,   24'd255000, -24'sd255000, 8'd0},
        '{1'b0, 1'b0, 8'd50,  16'd100, 24'd255000, -24'sd255000, 8'd24},
        '{1'b0, 1'b0, 8'd50,  16'd120, 24'd255000, -24'sd255000, 8'd50},
        '{1'b0, 1'b0, 8'd10,  16'd20,  24'd255000, -24'sd255000, 8'd46},
        '{1'b1, 1'b1, 8'd255, 16'd12,  24'd255000, -24'sd255000, 8'd43},
        '{1'b1, 1'b0, 8'd255, 16'd4,   -24'sd300,  24'd8388607,  8'd42}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_valid = 1'b0;
    logic [SW-1:0] left_in = '0;
    logic [SW-1:0] right_in = '0;
    logic          mute_pin = 1'b0;
    logic          mute_reg = 1'b0;
    logic [7:0]    att_level = 8'd200;
    logic [SW-1:0] left_out;
    logic [SW-1:0] right_out;
    logic          out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    soft_mute_ramp dut_i (
        .clk(clk), .rst(rst), .frame_valid(frame_valid),
        .left_in(left_in), .right_in(right_in),
        .mute_pin(mute_pin), .mute_reg(mute_reg), .att_level(att_level),
        .left_out(left_out), .right_out(right_out), .out_valid(out_valid)
    );

    function automatic longint ref_scale(input longint s, input longint g);
        return (s * g) / 255;
    endfunction

    function automatic string row_req(input int i);
        case (i)
            1: return "R1 R2";
            2: return "R3";
            3: return "R1 R2";
            4: return "R2";
            5: return "R3 R4";
            6: return "R3";
            7: return "R6";
            8: return "R1";
            9: return "R5";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One strobe, then (1 + gap) idle cycles; returns the registered result.
    task automatic send_frame(input logic [SW-1:0] l, input logic [SW-1:0] r, input int gap,
                              output longint lo, output longint ro, output logic vo);
        @(negedge clk);
        left_in = l; right_in = r; frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        lo = longint'($signed(left_out));
        ro = longint'($signed(right_out));
        vo = out_valid;
        for (int k = 0; k < gap; k++) @(negedge clk);
    endtask

    initial begin
        longint lo, ro;
        logic vo;
        repeat (3) @(negedge clk);
        check("R7", "left during reset", longint'($signed(left_out)), 0);
        check("R7", "valid during reset", longint'(out_valid), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            mute_pin = VECS[i].pin; mute_reg = VECS[i].rg; att_level = VECS[i].att;
            for (int f = 0; f < int'(VECS[i].frames); f++) begin
                send_frame(VECS[i].sl, VECS[i].sr, i % 3, lo, ro, vo);
            end
            check(row_req(i), $sformatf("row %0d left", i), lo,
                  ref_scale(longint'($signed(VECS[i].sl)), longint'(VECS[i].exp_gain)));
            check(row_req(i), $sformatf("row %0d right", i), ro,
                  ref_scale(longint'($signed(VECS[i].sr)), longint'(VECS[i].exp_gain)));
            check("R5", $sformatf("row %0d valid", i), longint'(vo), 1);
        end
        @(negedge clk);
        check("R5", "valid low when idle", longint'(out_valid), 0);

        // Leave the prescaler mid-count, then reset with a new code.
        send_frame(24'd1000, 24'd1000, 0, lo, ro, vo);
        send_frame(24'd1000, 24'd1000, 0, lo, ro, vo);
        @(negedge clk);
        rst = 1'b1; att_level = 8'd77; mute_pin = 1'b1; mute_reg = 1'b0;
        repeat (2) @(negedge clk);
        check("R7", "right during reset", longint'($signed(right_out)), 0);
        rst = 1'b0;
        send_frame(24'd255000, 24'd255000, 0, lo, ro, vo);
        check("R7", "index loaded from code", lo, 77000);
        send_frame(24'd255000, 24'd255000, 2, lo, ro, vo);
        send_frame(24'd255000, 24'd255000, 0, lo, ro, vo);
        send_frame(24'd255000, 24'd255000, 0, lo, ro, vo);
        check("R7", "fourth frame after reset", ro, 77000);
        send_frame(24'd255000, 24'd255000, 0, lo, ro, vo);
        check("R4", "first step after reset", lo, 76000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 R2 R3 R4 R5 R6 R7 R8: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule